// File: doc/BRIEF.md
# Flash Write-Cycle Qualification Guard

This block sits between an asynchronous host bus and a flash command decoder. It decides whether the activity on the active-low chip-enable, write-enable and output-enable strobes is a real write to the command register. It passes on only the cycles that are real writes. It samples the strobes and a low-supply lockout flag into the local clock domain. It then removes strobe levels that are too short to be intentional and applies the logical inhibit rules. It also refuses commands after power-up, and after a lockout, until the bus has been seen idle.

Each accepted write produces a single-cycle command strobe. The strobe carries the address and data captured when the write began. The guard also issues a one-cycle request to return to array-read mode in two cases: when it leaves reset, and when the supply enters lockout. Unlock-sequence checking for program and erase is the job of the downstream decoder.

Top module: `flash_wr_guard`

## Requirements
- R1: After reset is released, `read_reset` pulses high for exactly one cycle, and `cmd_valid` is low during and right after reset.
- R2: A write is accepted only when chip enable and write enable are both low (value 0) while output enable is high (value 1), after synchronization and filtering. It is committed when write enable or chip enable returns high while output enable is still high. The commit is one `cmd_valid` cycle, and `cmd_addr`/`cmd_data` carry the `bus_addr`/`bus_wdata` captured at the start of the write.
- R3: While output enable is low, no write is accepted, even with chip enable and write enable low.
- R4: While chip enable is high, write-enable pulses produce no command.
- R5: A strobe level held for fewer than `GLITCH_MIN` synchronized samples is ignored. This applies both to a short assertion from idle and to a short release during a write.
- R6: If chip enable and write enable are low with output enable high when reset is released, the following rise of write enable produces no command.
- R7: While `supply_low` is 1, no command is produced. A write in progress when lockout begins is discarded. Entering lockout causes one `read_reset` pulse.
- R8: After lockout or reset, no write is armed until both chip enable and write enable have been seen high together. An ordinary write after that is accepted.
- R9: `cmd_valid` never stays high for two consecutive cycles. The captured address and data stay constant while a write is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| bus_ce_n | input | 1 | Asynchronous chip enable, active low |
| bus_we_n | input | 1 | Asynchronous write enable, active low |
| bus_oe_n | input | 1 | Asynchronous output enable, active low |
| supply_low | input | 1 | Supply below lockout threshold, active high |
| bus_addr | input | ADDR_W | Host address, held stable during a write |
| bus_wdata | input | DATA_W | Host write data, held stable during a write |
| cmd_valid | output | 1 | One-cycle strobe for a qualified write |
| cmd_addr | output | ADDR_W | Address captured for the qualified write |
| cmd_data | output | DATA_W | Data captured for the qualified write |
| read_reset | output | 1 | One-cycle request to return to array-read mode |

## Verification
The assertions assume three things about the inputs:
- The host holds address and data steady from the start of a write until its end.
- `supply_low` is a level that lasts at least a few clock cycles.
- The strobes change no faster than the clock can sample them.

The stimulus meets these assumptions. It changes inputs only on falling clock edges, and it sets address and data before lowering chip enable. It keeps them fixed until both strobes have risen, and it holds each lockout period for several cycles. Short glitches are created on purpose as whole-cycle levels shorter than the filter threshold, so that their rejection is deterministic.

// File: rtl/fwg_pkg.sv
package fwg_pkg;

  typedef enum logic {
    QS_IDLE  = 1'b0,
    QS_ARMED = 1'b1
  } q_state_t;

  // Bus state that counts as a write: CE low, WE low, OE high.
  function automatic logic bus_qualifies(input logic ce_n, input logic we_n, input logic oe_n);
    return (!ce_n) && (!we_n) && oe_n;
  endfunction

  // Counter width needed to count up to n.
  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/fwg_sync.sv
module fwg_sync #(
  parameter int            W       = 1,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/fwg_glitch_filter.sv
module fwg_glitch_filter #(
  parameter int   MIN_SAMPLES = 3,
  parameter logic RST_VAL     = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  import fwg_pkg::*;

  localparam int CW = cnt_bits(MIN_SAMPLES);
  localparam logic [CW-1:0] LAST = CW'(MIN_SAMPLES - 1);

  logic [CW-1:0] run_cnt;
  logic          differs;
  logic          flip_now;

  assign differs  = (din != dout);
  assign flip_now = differs && (run_cnt >= LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= RST_VAL;
      run_cnt <= '0;
    end else if (flip_now) begin
      dout    <= din;
      run_cnt <= '0;
    end else if (differs) begin
      run_cnt <= run_cnt + 1'b1;
    end else begin
      run_cnt <= '0;
    end
  end

  // R5: the output only moves after the input had a differing value
  p_filter_needs_diff_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dout != $past(dout)) |-> ($past(din) != $past(dout)));

  // R5: a fresh run of differing samples never flips the output at once when MIN_SAMPLES > 1
  p_filter_no_instant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (MIN_SAMPLES > 1 && differs && run_cnt == '0) |=> (dout == $past(dout)));

endmodule

// File: rtl/fwg_qualifier.sv
module fwg_qualifier #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_f,
  input  logic              we_f,
  input  logic              oe_f,
  input  logic              vlow_s,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              cmd_valid,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic              read_reset
);
  import fwg_pkg::*;

  q_state_t state;
  logic     pu_block;
  logic     init_pend;
  logic     vlow_d;

  // Named events
  logic qual_now;
  logic bus_idle_seen;
  logic vlow_rise;
  logic arm_ev;
  logic commit_ev;
  logic abort_ev;

  assign qual_now      = bus_qualifies(ce_f, we_f, oe_f);
  assign bus_idle_seen = ce_f && we_f;
  assign vlow_rise     = vlow_s && !vlow_d;
  assign arm_ev        = (state == QS_IDLE) && qual_now && !pu_block && !vlow_s;
  assign commit_ev     = (state == QS_ARMED) && !vlow_s && !qual_now && oe_f;
  assign abort_ev      = (state == QS_ARMED) && (vlow_s || (!qual_now && !oe_f));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= QS_IDLE;
      pu_block   <= 1'b1;
      init_pend  <= 1'b1;
      vlow_d     <= 1'b1;
      cmd_valid  <= 1'b0;
      cmd_addr   <= '0;
      cmd_data   <= '0;
      read_reset <= 1'b0;
    end else begin
      vlow_d     <= vlow_s;
      init_pend  <= 1'b0;
      read_reset <= init_pend || vlow_rise;
      cmd_valid  <= commit_ev;

      if (vlow_s)             pu_block <= 1'b1;
      else if (bus_idle_seen) pu_block <= 1'b0;

      if (arm_ev) begin
        state    <= QS_ARMED;
        cmd_addr <= addr_in;
        cmd_data <= data_in;
      end else if (commit_ev || abort_ev) begin
        state <= QS_IDLE;
      end
    end
  end

  // R9: command strobe lasts one cycle
  p_single_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R7: lockout blocks any command in the next cycle
  p_lockout_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vlow_s |=> !cmd_valid);

  // R7: entering lockout requests array-read mode
  p_lockout_read_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vlow_s) |=> read_reset);

  // R6/R8: while inhibited no command emerges
  p_inhibit_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pu_block |=> !cmd_valid);

  // R9: captured fields stay put while armed
  p_latch_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == QS_ARMED && $past(state) == QS_ARMED) |-> ($stable(cmd_addr) && $stable(cmd_data)));

  // R3: with OE low nothing can be armed
  p_oe_low_no_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_f && state == QS_IDLE) |=> (state == QS_IDLE));

endmodule

// File: rtl/flash_wr_guard.sv
module flash_wr_guard #(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int GLITCH_MIN  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_ce_n,
  input  logic              bus_we_n,
  input  logic              bus_oe_n,
  input  logic              supply_low,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              cmd_valid,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic              read_reset
);

  localparam int NSTROBE = 3;
  // Strobes reset to asserted (0); lockout resets to active (1).
  localparam logic [NSTROBE:0] SYNC_RST = {1'b1, {NSTROBE{1'b0}}};

  logic [NSTROBE:0]   raw_in;
  logic [NSTROBE:0]   synced;
  logic [NSTROBE-1:0] filt;

  assign raw_in = {supply_low, bus_oe_n, bus_we_n, bus_ce_n};

  fwg_sync #(
    .W       (NSTROBE + 1),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (SYNC_RST)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .q     (synced)
  );

  for (genvar g = 0; g < NSTROBE; g++) begin : g_filt
    fwg_glitch_filter #(
      .MIN_SAMPLES (GLITCH_MIN),
      .RST_VAL     (1'b0)
    ) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (synced[g]),
      .dout  (filt[g])
    );
  end

  fwg_qualifier #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_qual (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_f       (filt[0]),
    .we_f       (filt[1]),
    .oe_f       (filt[2]),
    .vlow_s     (synced[NSTROBE]),
    .addr_in    (bus_addr),
    .data_in    (bus_wdata),
    .cmd_valid  (cmd_valid),
    .cmd_addr   (cmd_addr),
    .cmd_data   (cmd_data),
    .read_reset (read_reset)
  );

endmodule

// File: tb/test_flash_wr_guard.sv
module test_flash_wr_guard;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, vlow = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          cmd_valid, read_reset;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;

  int n_tests = 0, n_fail = 0, n_cmd = 0, n_rr = 0;
  logic prev_valid = 1'b0;
  logic [AW+DW-1:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_wr_guard i_flash_wr_guard (
    .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_we_n(we_n), .bus_oe_n(oe_n),
    .supply_low(vlow), .bus_addr(addr), .bus_wdata(wdata), .cmd_valid(cmd_valid),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .read_reset(read_reset)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (read_reset) n_rr++;
      if (cmd_valid) begin
        n_cmd++;
        chk(!prev_valid, "R9 strobe width", 2, 1);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected command", int'({cmd_addr, cmd_data}), 0);
        end else begin
          logic [AW+DW-1:0] e;
          e = exp_q.pop_front();
          chk({cmd_addr, cmd_data} == e, "R2 command payload",
              int'({cmd_addr, cmd_data}), int'(e));
        end
      end
      prev_valid = cmd_valid;
    end else begin
      prev_valid = 1'b0;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit expect_it);
    addr = a; wdata = d;
    if (expect_it) exp_q.push_back({a, d});
    ce_n = 1'b0; idle(1);
    we_n = 1'b0; idle(8);
    we_n = 1'b1; idle(2);
    ce_n = 1'b1; idle(10);
  endtask

  int c0, r0;

  initial begin
    idle(3);
    chk(cmd_valid == 1'b0, "R1 cmd low in reset", cmd_valid, 0);
    rst_n = 1'b1;
    idle(20);
    chk(n_rr == 1, "R1 one read_reset after reset", n_rr, 1);
    chk(n_cmd == 0, "R1 no command after reset", n_cmd, 0);

    // R2: ordinary writes with several patterns
    wr(11'h555, 16'h00AA, 1'b1);
    wr(11'h2AA, 16'h0055, 1'b1);
    wr(11'h7FF, 16'hFFFF, 1'b1);
    wr(11'h000, 16'h0000, 1'b1);
    chk(n_cmd == 4, "R2 four commands", n_cmd, 4);

    // R3: OE low inhibits
    c0 = n_cmd;
    oe_n = 1'b0; idle(2);
    wr(11'h123, 16'h1234, 1'b0);
    oe_n = 1'b1; idle(10);
    chk(n_cmd == c0, "R3 OE low inhibits", n_cmd, c0);

    // R4: CE high, WE pulses alone
    c0 = n_cmd;
    addr = 11'h321; wdata = 16'h4321;
    we_n = 1'b0; idle(8); we_n = 1'b1; idle(10);
    chk(n_cmd == c0, "R4 CE high inhibits", n_cmd, c0);

    // R5: short assert glitch ignored
    c0 = n_cmd;
    ce_n = 1'b0; idle(1);
    we_n = 1'b0; idle(2); we_n = 1'b1; idle(10);
    ce_n = 1'b1; idle(10);
    chk(n_cmd == c0, "R5 short WE pulse ignored", n_cmd, c0);

    // R5: short release glitch mid-write gives one command
    c0 = n_cmd;
    addr = 11'h0F0; wdata = 16'hBEEF;
    exp_q.push_back({11'h0F0, 16'hBEEF});
    ce_n = 1'b0; idle(1);
    we_n = 1'b0; idle(8);
    we_n = 1'b1; idle(2);
    we_n = 1'b0; idle(8);
    we_n = 1'b1; idle(2);
    ce_n = 1'b1; idle(10);
    chk(n_cmd == c0 + 1, "R5 release glitch ignored", n_cmd, c0 + 1);

    // R7: lockout blocks writes and pulses read_reset
    c0 = n_cmd; r0 = n_rr;
    vlow = 1'b1; idle(6);
    wr(11'h456, 16'h5678, 1'b0);
    chk(n_cmd == c0, "R7 no command in lockout", n_cmd, c0);
    chk(n_rr == r0 + 1, "R7 read_reset on lockout", n_rr, r0 + 1);
    vlow = 1'b0; idle(10);
    wr(11'h111, 16'h2222, 1'b1);
    chk(n_cmd == c0 + 1, "R7 write after lockout", n_cmd, c0 + 1);

    // R7/R8: lockout during a write discards it; held strobes stay blocked
    c0 = n_cmd;
    addr = 11'h0AA; wdata = 16'hCAFE;
    ce_n = 1'b0; idle(1);
    we_n = 1'b0; idle(8);
    vlow = 1'b1; idle(5);
    vlow = 1'b0; idle(12);
    we_n = 1'b1; idle(2);
    ce_n = 1'b1; idle(10);
    chk(n_cmd == c0, "R7 in-progress write aborted", n_cmd, c0);
    chk(n_cmd == c0, "R8 held strobes stay blocked", n_cmd, c0);
    wr(11'h333, 16'h4444, 1'b1);
    chk(n_cmd == c0 + 1, "R8 write after idle bus", n_cmd, c0 + 1);

    // R6: strobes asserted across reset release
    c0 = n_cmd; r0 = n_rr;
    idle(2);
    rst_n = 1'b0;
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    addr = 11'h5A5; wdata = 16'h9999;
    idle(3);
    rst_n = 1'b1; idle(20);
    we_n = 1'b1; idle(15);
    chk(n_cmd == c0, "R6 power-up rising WE ignored", n_cmd, c0);
    chk(n_rr == r0 + 1, "R1 read_reset after second reset", n_rr, r0 + 1);
    ce_n = 1'b1; idle(10);
    wr(11'h1C3, 16'h7E7E, 1'b1);
    chk(n_cmd == c0 + 1, "R6 write after idle bus", n_cmd, c0 + 1);

    idle(5);
    chk(exp_q.size() == 0, "R2 all expected commands seen", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule